// File: doc/BRIEF.md
# Double-Word Field Unit

This block is the shift, rotate, extract and insert datapath of a word-oriented execution unit. It takes two data words, called Left and Right, and one 16-bit field descriptor. From these it produces a single result word in the same cycle. The descriptor holds three fields: a shift count, a mask count and an insert flag.

The shift count moves the double word Left:Right to the left, and the upper word is kept. The mask count selects how many right-justified result bits come from that shifted word. The insert flag decides what fills the remaining bits: zeros, or the matching bits of Right.

The descriptor can come straight from the instruction as an immediate. It can also come from a held descriptor register. A setup strobe loads that register with the sum of a 16-bit immediate and a stack word. Common uses:

- Rotating a word: feed the same word on both inputs.
- Shifting a field left: feed the word and zero.
- Merging a field into a background word: set the insert flag.

Top module: `dword_field_unit`

## Requirements
- R1: After reset the descriptor register `field_q` reads 0.
- R2: On a rising clock edge with `desc_load` high, `field_q` takes the low 16 bits of `desc_imm + stack_top`. The sum wraps modulo 2^16. Without `desc_load`, `field_q` holds its value.
- R3: With `use_reg` high, the result uses `field_q` as its descriptor. With `use_reg` low, it uses `op_imm`. Operations with the immediate descriptor never change `field_q`.
- R4: The descriptor layout is shift count in bits [5:0], mask count in bits [11:6] and insert flag in bit 12. Bits [15:13] are reserved and have no effect on the result.
- R5: The shifted word is the upper 32 bits of the 64-bit value {left_in, right_in} shifted left by the shift count.
- R6: The mask count gives the number of right-justified mask ones. A count of 0 gives an empty mask, and 32 gives a full mask. Where the mask is 1, the result bit is the shifted-word bit.
- R7: Mask and shift counts above 32 are treated as 32. A shift of 32 passes `right_in` unchanged to the shifted word.
- R8: With the insert flag clear, result bits outside the mask are 0.
- R9: With the insert flag set, the lowest shift-count bits of the mask are cleared. Every result bit outside the trimmed mask is then taken from `right_in`.
- R10: With the same word x on both inputs, the unit rotates x left. The descriptor with insert 0, mask 30 and shift 30 gives x logically shifted right by 2.
- R11: With `right_in` = 0, shift s and mask m, the result is the right-justified field `left_in` shifted left by s and cut to m bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the descriptor register |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_load | input | 1 | Setup strobe that loads the descriptor register |
| desc_imm | input | 16 | Immediate added to the stack word on setup |
| stack_top | input | 32 | Stack word added to the immediate on setup |
| use_reg | input | 1 | 1 selects the descriptor register, 0 selects `op_imm` |
| op_imm | input | 16 | Immediate descriptor |
| left_in | input | 32 | Left (high) word of the double word |
| right_in | input | 32 | Right (low) word, also the insert background |
| result_out | output | 32 | Combinational result word |
| field_q | output | 16 | Current descriptor register contents |

## Verification
The bench builds the unit with its default 32-bit word. That gives 6-bit counts, whose codes run up to 63. Counts from 33 to 63 are therefore legal inputs, so the saturation path is reached by both directed and random descriptors. The same default leaves three reserved descriptor bits. Random immediates set those bits, and the results are compared with a reference that ignores them.

// File: rtl/fu_pkg.sv
package fu_pkg;

    localparam int WORD_W = 32;
    localparam int DESC_W = 16;
    localparam int CNT_W  = $clog2(WORD_W) + 1;

    typedef struct packed {
        logic             ins;
        logic [CNT_W-1:0] mcnt;
        logic [CNT_W-1:0] scnt;
    } fdesc_t;

    // Clamp a count to the word width.
    function automatic logic [CNT_W-1:0] sat_cnt(input logic [CNT_W-1:0] c);
        return (c > CNT_W'(WORD_W)) ? CNT_W'(WORD_W) : c;
    endfunction

    // Unpack a raw descriptor: shift low, mask next, insert above; upper bits unused.
    function automatic fdesc_t decode(input logic [DESC_W-1:0] raw);
        fdesc_t d;
        d.scnt = sat_cnt(raw[CNT_W-1:0]);
        d.mcnt = sat_cnt(raw[2*CNT_W-1:CNT_W]);
        d.ins  = raw[2*CNT_W];
        return d;
    endfunction

endpackage

// File: rtl/fu_desc_reg.sv
module fu_desc_reg #(
    parameter int DESC_W = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DESC_W-1:0] imm,
    input  logic [WORD_W-1:0] top,
    output logic [DESC_W-1:0] field
);

    typedef struct packed {
        logic [DESC_W-1:0] field;
    } state_t;

    state_t state_d, state_q;
    logic [WORD_W-1:0] sum_w;

    always_comb begin
        state_d = state_q;
        sum_w   = WORD_W'(imm) + top;
        if (load) begin
            state_d.field = sum_w[DESC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign field = state_q.field;

endmodule

// File: rtl/fu_funnel.sv
module fu_funnel #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic [W-1:0]  hi_word,
    input  logic [W-1:0]  lo_word,
    input  logic [CW-1:0] shamt,
    output logic [W-1:0]  shifted
);

    logic [2*W-1:0] dword;

    always_comb begin
        dword   = {hi_word, lo_word} << shamt;
        shifted = dword[2*W-1:W];
    end

endmodule

// File: rtl/fu_mask_gen.sv
module fu_mask_gen #(
    parameter int W  = 32,
    parameter int CW = 6
) (
    input  logic [CW-1:0] mcnt,
    input  logic [CW-1:0] scnt,
    input  logic          ins,
    output logic [W-1:0]  mask
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic in_field;
        logic trimmed;
        assign in_field = CW'(i) < mcnt;
        assign trimmed  = ins && (CW'(i) < scnt);
        assign mask[i]  = in_field && !trimmed;
    end

endmodule

// File: rtl/dword_field_unit.sv
module dword_field_unit
    import fu_pkg::*;
#(
    parameter int WORD_W_P = fu_pkg::WORD_W,
    parameter int DESC_W_P = fu_pkg::DESC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                desc_load,
    input  logic [DESC_W_P-1:0] desc_imm,
    input  logic [WORD_W_P-1:0] stack_top,
    input  logic                use_reg,
    input  logic [DESC_W_P-1:0] op_imm,
    input  logic [WORD_W_P-1:0] left_in,
    input  logic [WORD_W_P-1:0] right_in,
    output logic [WORD_W_P-1:0] result_out,
    output logic [DESC_W_P-1:0] field_q
);

    fdesc_t              dsel;
    logic [WORD_W_P-1:0] shifted;
    logic [WORD_W_P-1:0] mask;
    logic [WORD_W_P-1:0] backdrop;

    fu_desc_reg #(.DESC_W(DESC_W_P), .WORD_W(WORD_W_P)) i_desc_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (desc_load),
        .imm   (desc_imm),
        .top   (stack_top),
        .field (field_q)
    );

    always_comb begin
        dsel = decode(use_reg ? field_q : op_imm);
    end

    fu_funnel #(.W(WORD_W_P), .CW(CNT_W)) i_funnel (
        .hi_word (left_in),
        .lo_word (right_in),
        .shamt   (dsel.scnt),
        .shifted (shifted)
    );

    fu_mask_gen #(.W(WORD_W_P), .CW(CNT_W)) i_mask (
        .mcnt (dsel.mcnt),
        .scnt (dsel.scnt),
        .ins  (dsel.ins),
        .mask (mask)
    );

    always_comb begin
        backdrop   = dsel.ins ? right_in : '0;
        result_out = (shifted & mask) | (backdrop & ~mask);
    end

endmodule

// File: rtl/fu_checker.sv
module fu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        desc_load,
    input logic [15:0] desc_imm,
    input logic [31:0] stack_top,
    input logic        use_reg,
    input logic [15:0] op_imm,
    input logic [31:0] right_in,
    input logic [31:0] result_out,
    input logic [15:0] field_q
);

    logic [15:0] raw;
    logic [5:0]  m_raw;
    logic [5:0]  s_raw;
    logic        ins_b;
    logic [31:0] hi_zero_chk;

    always_comb begin
        raw         = use_reg ? field_q : op_imm;
        s_raw       = raw[5:0];
        m_raw       = raw[11:6];
        ins_b       = raw[12];
        hi_zero_chk = (m_raw < 6'd32) ? (result_out >> m_raw) : 32'd0;
    end

    assert_field_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_load |=> $stable(field_q));

    assert_field_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_load |=> field_q == $past(desc_imm + stack_top[15:0]));

    assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_b && m_raw < 6'd32) |-> hi_zero_chk == 32'd0);

    assert_full_shift_insert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_b && s_raw >= 6'd32) |-> result_out == right_in);

    assert_saturated_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_raw >= 6'd32 && m_raw >= 6'd32) |-> result_out == right_in);

endmodule

bind dword_field_unit fu_checker i_fu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_load  (desc_load),
    .desc_imm   (desc_imm),
    .stack_top  (stack_top),
    .use_reg    (use_reg),
    .op_imm     (op_imm),
    .right_in   (right_in),
    .result_out (result_out),
    .field_q    (field_q)
);

// File: tb/test_dword_field_unit.sv
module test_dword_field_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_load = 1'b0;
    logic [15:0] desc_imm = '0;
    logic [31:0] stack_top = '0;
    logic        use_reg = 1'b0;
    logic [15:0] op_imm = '0;
    logic [31:0] left_in = '0;
    logic [31:0] right_in = '0;
    logic [31:0] result_out;
    logic [15:0] field_q;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    dword_field_unit i_dword_field_unit (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_imm(desc_imm),
        .stack_top(stack_top), .use_reg(use_reg), .op_imm(op_imm),
        .left_in(left_in), .right_in(right_in), .result_out(result_out),
        .field_q(field_q)
    );

    function automatic int satc(input int c);
        return (c > 32) ? 32 : c;
    endfunction

    function automatic logic [31:0] ref_fu(input logic [31:0] l, input logic [31:0] r,
                                           input logic [15:0] d);
        logic [63:0] dw;
        logic [31:0] res;
        int s, m;
        logic ins;
        s   = satc(int'(d[5:0]));
        m   = satc(int'(d[11:6]));
        ins = d[12];
        dw  = {l, r};
        for (int i = 0; i < 32; i++) begin
            if (i < m && !(ins && i < s)) res[i] = dw[i + 32 - s];
            else                          res[i] = ins ? r[i] : 1'b0;
        end
        return res;
    endfunction

    function automatic logic [15:0] mkd(input logic ins, input int m, input int s);
        return {3'b000, ins, 6'(m), 6'(s)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] l, input logic [31:0] r, input logic [15:0] d);
        @(negedge clk);
        use_reg  = 1'b0;
        left_in  = l;
        right_in = r;
        op_imm   = d;
        #1;
    endtask

    task automatic setup(input logic [15:0] imm, input logic [31:0] top);
        @(negedge clk);
        desc_load = 1'b1;
        desc_imm  = imm;
        stack_top = top;
        @(negedge clk);
        desc_load = 1'b0;
        stack_top = $urandom;
        #1;
    endtask

    initial begin
        void'($urandom(32'd1985));
        repeat (3) @(negedge clk);
        #1;
        check("R1 field reset", 32'(field_q), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 rotate / right shift by 2
        apply(32'hDEADBEEF, 32'hDEADBEEF, mkd(1'b0, 30, 30));
        check("R10 shr2", result_out, 32'hDEADBEEF >> 2);
        apply(32'h80000001, 32'h80000001, mkd(1'b0, 32, 4));
        check("R10 rotl4", result_out, 32'h00000018);

        // R11 field shift left with zero right word
        apply(32'h000000AB, 32'h0, mkd(1'b0, 16, 8));
        check("R11 shl", result_out, 32'h0000AB00);

        // R6 empty and full mask
        apply(32'h12345678, 32'hFFFFFFFF, mkd(1'b0, 0, 3));
        check("R6 mask0", result_out, 32'h0);
        apply(32'h12345678, 32'h9ABCDEF0, mkd(1'b0, 32, 0));
        check("R6 mask32", result_out, 32'h12345678);

        // R5 funnel across the word boundary
        apply(32'h0000000F, 32'hF0000000, mkd(1'b0, 32, 4));
        check("R5 funnel", result_out, 32'h000000FF);

        // R7 saturation
        apply(32'hCAFEBABE, 32'h0BADF00D, mkd(1'b0, 63, 40));
        check("R7 sat pass right", result_out, 32'h0BADF00D);
        apply(32'hCAFEBABE, 32'h0BADF00D, mkd(1'b0, 50, 0));
        check("R7 mask sat", result_out, 32'hCAFEBABE);

        // R8 zeros outside mask
        apply(32'hFFFFFFFF, 32'hFFFFFFFF, mkd(1'b0, 5, 0));
        check("R8 zero fill", result_out, 32'h0000001F);

        // R9 insert: mask bits 4..7 from shifted, rest from right
        apply(32'h0000000A, 32'h11111111, mkd(1'b1, 8, 4));
        check("R9 insert", result_out, 32'h111111A1);
        apply(32'h0000000A, 32'h11111111, mkd(1'b1, 8, 32));
        check("R9 insert full trim", result_out, 32'h11111111);

        // R4 reserved bits ignored
        apply(32'h0000000A, 32'h11111111, {3'b111, 1'b1, 6'd8, 6'd4});
        check("R4 reserved", result_out, 32'h111111A1);

        // R2 setup load and wrap
        setup(16'h0100, 32'hFFFF0205);
        check("R2 load", 32'(field_q), 32'h0305);
        setup(16'hFFFF, 32'h00000002);
        check("R2 wrap", 32'(field_q), 32'h0001);

        // R3 register source, immediate ops leave it alone
        setup(16'h0000, 32'(mkd(1'b1, 12, 4)));
        @(negedge clk);
        use_reg  = 1'b1;
        left_in  = 32'h00000ABC;
        right_in = 32'h55555555;
        op_imm   = mkd(1'b0, 0, 0);
        #1;
        check("R3 reg source", result_out, ref_fu(32'h00000ABC, 32'h55555555, mkd(1'b1, 12, 4)));
        for (int k = 0; k < 20; k++) begin
            apply($urandom, $urandom, 16'($urandom));
        end
        @(negedge clk);
        #1;
        check("R3 reg unchanged", 32'(field_q), 32'(mkd(1'b1, 12, 4)));

        // R5/R4 random immediate descriptors
        for (int k = 0; k < 400; k++) begin
            logic [31:0] l, r;
            logic [15:0] d;
            l = $urandom;
            r = $urandom;
            d = 16'($urandom);
            apply(l, r, d);
            check("R5 random", result_out, ref_fu(l, r, d));
        end

        // R10 random rotates
        for (int k = 0; k < 50; k++) begin
            logic [31:0] x;
            int s;
            x = $urandom;
            s = int'($urandom_range(0, 31));
            apply(x, x, mkd(1'b0, 32, s));
            check("R10 rotate", result_out, (x << s) | (s == 0 ? 32'h0 : x >> (32 - s)));
        end

        // R2/R3 random loads then register-sourced ops
        for (int k = 0; k < 40; k++) begin
            logic [15:0] imm;
            logic [31:0] top, l, r, sum;
            imm = 16'($urandom);
            top = $urandom;
            sum = 32'(imm) + top;
            setup(imm, top);
            check("R2 random load", 32'(field_q), 32'(sum[15:0]));
            l = $urandom;
            r = $urandom;
            @(negedge clk);
            use_reg  = 1'b1;
            left_in  = l;
            right_in = r;
            op_imm   = 16'($urandom);
            #1;
            check("R3 random reg", result_out, ref_fu(l, r, sum[15:0]));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule